// File: doc/BRIEF.md
# Staged Rotate-Exchange Permutation Unit

This block rearranges the bits of a 32-bit word through a fixed network of five conditional shift layers. It generalises a plain rotate. The layers move bits by 16, 8, 4, 2 and then 1 position. Two 5-bit amounts, `in_shift` and `in_shiftx`, control the layers. Within a layer, each bit position picks one of the two amounts from its own index, so different regions of the word can move by different distances. A stripe flag inverts the amount chosen in the widest layer for half of the positions. This produces interleaved exchange patterns that a single rotate cannot produce.

The network works on a doubled copy of the source. The upper half of that copy is the source again, so bits shifted down come in from above as they would in a rotate. After the last layer the low 32 bits are taken and sign-extended to the output width. When the two amounts are equal and the stripe flag is clear, the unit is an ordinary right rotate.

Operands are sampled on the clock edge where `in_valid` is high, and the permuted word is captured in an output register at that same edge. The result therefore appears one cycle after the request and stays there until the next request. There is no state machine. The design is one register stage, with `out_valid` as the only control bit.

Top module: `rxp_unit`

## Requirements
- R1: While reset is asserted and after it is released, `out_valid` is 0 and `out_result` is all zeros until the first request.
- R2: `out_valid` is 1 in exactly the cycle after each cycle in which `in_valid` was 1, and 0 after every cycle in which `in_valid` was 0.
- R3: While `in_valid` is 0, `out_result` keeps its value whatever the operand inputs do.
- R4: With `in_shift` equal to `in_shiftx` and `in_stripe` 0, the low 32 bits of the result equal the source rotated right by `in_shift`.
- R5: The working word starts as {src, src} (64 bits). The layers with distance 16, 8, 4, 2 and 1 are applied in that order. In the layer with distance k, bit i takes bit i+k of the previous layer's value when the layer is enabled for i, and otherwise keeps its own value. The layers cover bits 0..46, 0..38, 0..34, 0..32 and 0..31 respectively, and bits above a layer's range pass through it unchanged.
- R6: The amount that controls bit i is `in_shift` when index bit 3 of i is set (layer 16), index bit 2 is set (layer 8), index bit 1 is set (layer 4) or index bit 0 is set (layer 2). Otherwise it is `in_shiftx`. Layer 1 always uses `in_shift`. The layer is enabled when amount bit 4, 3, 2, 1 or 0 is set, matching layer 16, 8, 4, 2 or 1.
- R7: When `in_stripe` is 1, and in layer 16 only, the chosen amount is bitwise inverted for positions whose index bit 2 is clear.
- R8: Bits 63..32 of `out_result` are copies of result bit 31.
- R9: With both amounts 0 and `in_stripe` 0, the result is the source unchanged (sign-extended).
- R10: A zero source always gives a zero result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Request strobe; operands are sampled when high |
| in_src | input | 32 | Source word |
| in_shift | input | 5 | Primary amount |
| in_shiftx | input | 5 | Alternate amount |
| in_stripe | input | 1 | Inverts the layer-16 amount for positions with index bit 2 clear |
| out_valid | output | 1 | High for one cycle after each request |
| out_result | output | 64 | Permuted word, sign-extended from bit 31 |

## Verification
The assertions expect `in_valid` and the operand inputs to be driven to known values from reset onward. They also rely on the operands being stable around the sampling edge, since the rotate and zero-source properties compare the result with the operands of the previous cycle. The bench meets these conditions by driving every input only at the falling clock edge and by holding all inputs at zero during reset. Random operands are drawn from a seeded generator over the full range of the source word, both amounts and the stripe flag. Directed cases cover equal amounts, zero amounts, stripe with zero amounts, a negative result and a zero source.

// File: rtl/rxp_pkg.sv
package rxp_pkg;

    // Highest bit index touched by the layer of distance 2**j in a network
    // of lg layers over a doubled word of 2*w bits. The widest layer stops
    // at 2w-2-2**(lg-1); every narrower layer ends its own distance lower.
    function automatic int layer_top(input int w, input int lg, input int j);
        int v;
        v = 2 * w - 2;
        for (int t = lg - 1; t >= j; t--) begin
            v = v - (1 << t);
        end
        return v;
    endfunction

    // Right rotate of a word of up to 64 bits, used by the checks.
    function automatic logic [63:0] rot_right(input logic [63:0] v, input int w, input int amt);
        logic [63:0] r;
        r = '0;
        for (int b = 0; b < w; b++) begin
            r[b] = v[(b + amt) % w];
        end
        return r;
    endfunction

endpackage

// File: rtl/rxp_stage.sv
module rxp_stage #(
    parameter int W2        = 64,
    parameter int J         = 4,
    parameter int TOP       = 46,
    parameter bit STRIPE_ON = 1'b1
) (
    input  logic [W2-1:0] din,
    input  logic          sh_bit,
    input  logic          shx_bit,
    input  logic          stripe,
    output logic [W2-1:0] dout
);
    localparam int K = 1 << J;

    logic unused_in;
    assign unused_in = stripe ^ shx_bit;

    for (genvar i = 0; i < W2; i++) begin : g_bit
        if (i <= TOP) begin : g_move
            logic base_en;
            logic en;
            if (J == 0) begin : g_prim
                assign base_en = sh_bit;
            end else if (((i >> (J - 1)) & 1) == 1) begin : g_sel_sh
                assign base_en = sh_bit;
            end else begin : g_sel_shx
                assign base_en = shx_bit;
            end
            if (STRIPE_ON && (J >= 2) && (((i >> (J - 2)) & 1) == 0)) begin : g_inv
                assign en = stripe ? ~base_en : base_en;
            end else begin : g_plain
                assign en = base_en;
            end
            assign dout[i] = en ? din[i + K] : din[i];
        end else begin : g_pass
            assign dout[i] = din[i];
        end
    end

    // Bits above the layer's range must leave it untouched (R5)
    always_comb begin
        if (TOP + 1 < W2) begin
            AST_ABOVE_TOP_PASS: assert (dout[W2-1] == din[W2-1]); // R5
        end
    end

endmodule

// File: rtl/rxp_network.sv
module rxp_network #(
    parameter int W  = 32,
    parameter int AW = $clog2(W)
) (
    input  logic [W-1:0]  src,
    input  logic [AW-1:0] shift,
    input  logic [AW-1:0] shiftx,
    input  logic          stripe,
    output logic [W-1:0]  perm
);
    import rxp_pkg::*;

    localparam int LG = AW;
    localparam int W2 = 2 * W;

    logic [W2-1:0] lvl [0:LG];

    assign lvl[0] = {src, src};

    for (genvar s = 0; s < LG; s++) begin : g_layer
        localparam int JJ = LG - 1 - s;
        rxp_stage #(
            .W2        (W2),
            .J         (JJ),
            .TOP       (layer_top(W, LG, JJ)),
            .STRIPE_ON (JJ == LG - 1)
        ) u_stage (
            .din     (lvl[s]),
            .sh_bit  (shift[JJ]),
            .shx_bit (shiftx[JJ]),
            .stripe  (stripe),
            .dout    (lvl[s+1])
        );
    end

    logic [W-1:0] unused_hi;
    assign unused_hi = lvl[LG][W2-1:W];
    assign perm      = lvl[LG][W-1:0];

endmodule

// File: rtl/rxp_unit.sv
module rxp_unit #(
    parameter int W     = 32,
    parameter int OUT_W = 64
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   in_valid,
    input  logic [W-1:0]           in_src,
    input  logic [$clog2(W)-1:0]   in_shift,
    input  logic [$clog2(W)-1:0]   in_shiftx,
    input  logic                   in_stripe,
    output logic                   out_valid,
    output logic [OUT_W-1:0]       out_result
);
    import rxp_pkg::*;

    localparam int AW  = $clog2(W);
    localparam int EXT = OUT_W - W;

    logic [W-1:0] perm;

    rxp_network #(.W(W), .AW(AW)) u_net (
        .src    (in_src),
        .shift  (in_shift),
        .shiftx (in_shiftx),
        .stripe (in_stripe),
        .perm   (perm)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
        end else begin
            out_valid <= in_valid;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_result <= '0;
        end else if (in_valid) begin
            out_result <= {{EXT{perm[W-1]}}, perm};
        end
    end

    AST_VALID_RISE: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid); // R2
    AST_VALID_DROP: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid); // R2
    AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> $stable(out_result)); // R3
    AST_PLAIN_ROTATE: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && (in_shift == in_shiftx) && !in_stripe) |=>
        (out_result[W-1:0] == W'(rot_right(64'($past(in_src)), W, int'($past(in_shift)))))); // R4
    AST_ZERO_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && (in_src == '0)) |=> (out_result == '0)); // R10

endmodule

// File: tb/tb_rxp_unit.sv
module tb_rxp_unit;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        in_valid;
    logic [31:0] in_src;
    logic [4:0]  in_shift;
    logic [4:0]  in_shiftx;
    logic        in_stripe;
    logic        out_valid;
    logic [63:0] out_result;

    int checks = 0;
    int errors = 0;
    logic [63:0] res;
    logic        vld;

    always #(CLK_PERIOD / 2) clk = ~clk;

    rxp_unit dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .in_valid   (in_valid),
        .in_src     (in_src),
        .in_shift   (in_shift),
        .in_shiftx  (in_shiftx),
        .in_stripe  (in_stripe),
        .out_valid  (out_valid),
        .out_result (out_result)
    );

    // Reference built from the requirement text (R5, R6, R7, R8)
    function automatic logic [63:0] model(input logic [31:0] src, input logic [4:0] sh,
                                          input logic [4:0] shx, input logic st);
        logic [63:0] cur;
        logic [63:0] nxt;
        logic [4:0]  c;
        int          top;
        cur = {src, src};
        top = 62;
        for (int j = 4; j >= 0; j--) begin
            top = top - (1 << j);
            nxt = cur;
            for (int i = 0; i <= top; i++) begin
                if (j == 0) c = sh;
                else c = (((i >> (j - 1)) & 1) == 1) ? sh : shx;
                if (st && j == 4 && (((i >> 2) & 1) == 0)) c = ~c;
                if (c[j]) nxt[i] = cur[i + (1 << j)];
            end
            cur = nxt;
        end
        return {{32{cur[31]}}, cur[31:0]};
    endfunction

    function automatic logic [63:0] rotr(input logic [31:0] v, input int a);
        logic [31:0] r;
        r = (v >> a) | (v << ((32 - a) % 32));
        if (a == 0) r = v;
        return {{32{r[31]}}, r};
    endfunction

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic run_op(input logic [31:0] s, input logic [4:0] a, input logic [4:0] b,
                          input logic st, output logic [63:0] r, output logic v);
        @(negedge clk);
        in_src = s; in_shift = a; in_shiftx = b; in_stripe = st; in_valid = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
        r = out_result;
        v = out_valid;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        logic [63:0] held;
        int seed_dummy;
        seed_dummy = $urandom(32'h5EED_0042);
        rst_n = 1'b0; in_valid = 1'b0; in_src = '0;
        in_shift = '0; in_shiftx = '0; in_stripe = 1'b0;
        repeat (3) @(negedge clk);
        chk("R1 valid in reset", 64'(out_valid), 64'd0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 valid after reset", 64'(out_valid), 64'd0);
        chk("R1 result after reset", out_result, 64'd0);

        // R4 plain rotate cases
        run_op(32'h1234_5678, 5'd7, 5'd7, 1'b0, res, vld);
        chk("R2 valid after request", 64'(vld), 64'd1);
        chk("R4 rotate by 7", res, rotr(32'h1234_5678, 7));
        run_op(32'h8000_0001, 5'd31, 5'd31, 1'b0, res, vld);
        chk("R4 rotate by 31", res, rotr(32'h8000_0001, 31));
        run_op(32'h0F0F_00FF, 5'd16, 5'd16, 1'b0, res, vld);
        chk("R4 rotate by 16", res, rotr(32'h0F0F_00FF, 16));

        // R9 identity
        run_op(32'hDEAD_BEEF, 5'd0, 5'd0, 1'b0, res, vld);
        chk("R9 zero amounts identity", res, 64'hFFFF_FFFF_DEAD_BEEF);

        // R2 drop: next cycle had no request
        @(negedge clk);
        chk("R2 valid drops", 64'(out_valid), 64'd0);

        // R3 hold while idle with moving operands
        held = out_result;
        in_src = 32'hA5A5_5A5A; in_shift = 5'd3; in_shiftx = 5'd19; in_stripe = 1'b1;
        repeat (2) @(negedge clk);
        chk("R3 result held while idle", out_result, held);

        // R7 stripe with zero amounts: inverted layer-16 control
        run_op(32'h0000_FFFF, 5'd0, 5'd0, 1'b1, res, vld);
        chk("R7 stripe zero amounts", res, model(32'h0000_FFFF, 5'd0, 5'd0, 1'b1));
        chk("R7 stripe changes result", 64'(res != 64'h0000_0000_0000_FFFF), 64'd1);

        // R6 split amounts
        run_op(32'h0123_4567, 5'd16, 5'd0, 1'b0, res, vld);
        chk("R6 split amounts 16/0", res, model(32'h0123_4567, 5'd16, 5'd0, 1'b0));
        run_op(32'h89AB_CDEF, 5'd5, 5'd26, 1'b0, res, vld);
        chk("R6 split amounts 5/26", res, model(32'h89AB_CDEF, 5'd5, 5'd26, 1'b0));

        // R8 sign extension of a negative result
        run_op(32'h0000_0001, 5'd1, 5'd1, 1'b0, res, vld);
        chk("R8 upper bits copy bit 31", res, 64'hFFFF_FFFF_8000_0000);

        // R10 zero source
        run_op(32'h0, 5'd13, 5'd22, 1'b1, res, vld);
        chk("R10 zero source", res, 64'd0);

        // R5 random sweep
        for (int n = 0; n < 300; n++) begin
            logic [31:0] s;
            logic [4:0]  a;
            logic [4:0]  b;
            logic        st;
            s  = $urandom;
            a  = 5'($urandom);
            b  = 5'($urandom);
            st = 1'($urandom);
            run_op(s, a, b, st, res, vld);
            chk("R5 random permutation", res, model(s, a, b, st));
        end

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule